// File: doc/BRIEF.md
# Lockable CAN Transmit Message Buffer

This block stores one outgoing CAN frame of ten bytes: an identifier byte at address 0, a control byte at address 1 and up to eight data bytes at addresses 2 to 9. A host CPU fills the storage and then raises a transmission request. The request hands the storage to the bit-stream engine, which reads the frame through its own port for as long as it needs.

Ownership moves only on defined events. While the buffer is released, only the CPU reaches the storage. While it is locked, only the engine does. The lock stays set through any number of automatic retransmissions. It clears only when the engine signals that the transfer finished or was aborted. The storage has a single port, and the lock state drives the multiplexer that selects which side's address reaches it.

Top module: `can_tx_msg_buf`

## Requirements
- R1: After reset, `locked` is 0, `access_viol` is 0, `eng_rdata` is 0 and every CPU read of addresses 0 to 9 returns 0.
- R2: While released, a CPU write with `cpu_wr_en`=1 stores `cpu_wdata` at `cpu_addr` (0 to 9). A combinational CPU read of that address returns the byte from the next cycle on.
- R3: A `cpu_tx_req` pulse while released sets `locked` to 1 on the next cycle. While locked, `cpu_rdata` is 0, and CPU writes leave the stored bytes unchanged.
- R4: A CPU write attempted while locked sets `access_viol` on the next cycle. The flag stays set until a cycle with `viol_clr`=1 and no new violation, after which it reads 0. A violation in the same cycle as `viol_clr` keeps the flag set.
- R5: A `cpu_tx_req` while already locked is ignored. It neither extends the lock nor re-locks the buffer after release.
- R6: While locked, `eng_done`=1 or `eng_abort`=1 clears `locked` on the next cycle. Without either, the buffer stays locked, which covers retries.
- R7: While locked, `eng_rd_en`=1 with `eng_addr` 0 to 9 puts that stored byte on `eng_rdata` one cycle later. Addresses 10 to 15, or any engine read while released, give 0.
- R8: A CPU read of address 1 returns the upper four bits of the control byte unchanged. The lower four bits (data-length code) are clamped to 8 when the stored value exceeds 8. The engine port returns the raw control byte.
- R9: CPU writes to addresses 10 to 15 are ignored, and CPU reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 4 | CPU byte address |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational |
| cpu_tx_req | input | 1 | Transmission request pulse |
| viol_clr | input | 1 | Clears the access-violation flag |
| access_viol | output | 1 | Sticky flag for a write attempted while locked |
| locked | output | 1 | 1 = engine owns the storage |
| eng_rd_en | input | 1 | Engine read strobe |
| eng_addr | input | 4 | Engine byte address |
| eng_rdata | output | 8 | Engine read data, one cycle after the strobe |
| eng_done | input | 1 | Transfer complete |
| eng_abort | input | 1 | Transfer aborted |

## Verification
The bench writes a frame, locks it, and then attempts a CPU write while locked. After release, a byte that changed would show that the single port let the CPU through. It issues a second request during the lock and checks that the lock does not come back after `eng_done`, which catches a design that queues requests. It stores a data-length code of 12 and expects 8 on the CPU side but the raw byte on the engine side, so a clamp placed in the storage path or missing altogether is caught. It also clears the violation flag in the same cycle as a new violation, which exposes a clear that wins over a set.

// File: rtl/can_tx_msg_buf.sv
module can_tx_msg_buf #(
  parameter int DATA_W   = 8,
  parameter int MAX_DLEN = 8,
  parameter int AW       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     cpu_addr,
  input  logic              cpu_wr_en,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              cpu_tx_req,
  input  logic              viol_clr,
  output logic              access_viol,
  output logic              locked,
  input  logic              eng_rd_en,
  input  logic [AW-1:0]     eng_addr,
  output logic [DATA_W-1:0] eng_rdata,
  input  logic              eng_done,
  input  logic              eng_abort
);
  localparam int DEPTH    = 2 + MAX_DLEN;
  localparam int CTRL_IDX = 1;
  localparam int DLC_W    = 4;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              locked_q, viol_q;
  logic [DATA_W-1:0] port_q, eng_q;
  logic [DLC_W-1:0]  dlc_clamped;

  wire [AW-1:0] port_addr = locked_q ? eng_addr : cpu_addr;
  wire          port_we   = !locked_q && cpu_wr_en;

  always_comb begin
    port_q = '0;
    for (int i = 0; i < DEPTH; i++)
      if (port_addr == AW'(i)) port_q = mem[i];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)                                mem[g] <= '0;
      else if (port_we && port_addr == AW'(g))   mem[g] <= cpu_wdata;
    end
  end

  assign dlc_clamped = (port_q[DLC_W-1:0] > DLC_W'(MAX_DLEN)) ? DLC_W'(MAX_DLEN)
                                                               : port_q[DLC_W-1:0];

  assign cpu_rdata = locked_q                   ? '0 :
                     (cpu_addr == AW'(CTRL_IDX)) ? {port_q[DATA_W-1:DLC_W], dlc_clamped} :
                                                  port_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      viol_q   <= 1'b0;
      eng_q    <= '0;
    end else begin
      if (!locked_q && cpu_tx_req)               locked_q <= 1'b1;
      else if (locked_q && (eng_done || eng_abort)) locked_q <= 1'b0;
      if (locked_q && cpu_wr_en)                 viol_q <= 1'b1;
      else if (viol_clr)                         viol_q <= 1'b0;
      eng_q <= (locked_q && eng_rd_en) ? port_q : '0;
    end
  end

  assign locked      = locked_q;
  assign access_viol = viol_q;
  assign eng_rdata   = eng_q;
endmodule

module can_tx_msg_buf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cpu_addr,
  input logic       cpu_wr_en,
  input logic [7:0] cpu_rdata,
  input logic       cpu_tx_req,
  input logic       viol_clr,
  input logic       access_viol,
  input logic       locked,
  input logic [7:0] eng_rdata,
  input logic       eng_done,
  input logic       eng_abort
);
  AST_LOCK_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n) !locked && cpu_tx_req |=> locked); // R3
  AST_CPU_BLIND: assert property (@(posedge clk) disable iff (!rst_n) locked |-> cpu_rdata == 8'h00); // R3
  AST_VIOL_SET: assert property (@(posedge clk) disable iff (!rst_n) locked && cpu_wr_en |=> access_viol); // R4
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) access_viol && !viol_clr |=> access_viol); // R4
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) locked && (eng_done || eng_abort) |=> !locked); // R6
  AST_HOLD_LOCK: assert property (@(posedge clk) disable iff (!rst_n) locked && !eng_done && !eng_abort |=> locked); // R6
  AST_ENG_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !locked |=> eng_rdata == 8'h00); // R7
  AST_DLC_CLAMP: assert property (@(posedge clk) disable iff (!rst_n) cpu_addr == 4'd1 |-> cpu_rdata[3:0] <= 4'd8); // R8
  AST_HIGH_ADDR: assert property (@(posedge clk) disable iff (!rst_n) cpu_addr > 4'd9 |-> cpu_rdata == 8'h00); // R9
endmodule

bind can_tx_msg_buf can_tx_msg_buf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr_en(cpu_wr_en),
  .cpu_rdata(cpu_rdata), .cpu_tx_req(cpu_tx_req), .viol_clr(viol_clr),
  .access_viol(access_viol), .locked(locked), .eng_rdata(eng_rdata),
  .eng_done(eng_done), .eng_abort(eng_abort)
);

// File: tb/can_tx_msg_buf_test.sv
module can_tx_msg_buf_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cpu_addr = '0;
  logic       cpu_wr_en = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       cpu_tx_req = 1'b0;
  logic       viol_clr = 1'b0;
  logic       access_viol;
  logic       locked;
  logic       eng_rd_en = 1'b0;
  logic [3:0] eng_addr = '0;
  logic [7:0] eng_rdata;
  logic       eng_done = 1'b0;
  logic       eng_abort = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    int         sig;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t exp_q[$];

  always #5 clk = ~clk;

  can_tx_msg_buf uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr_en(cpu_wr_en),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_tx_req(cpu_tx_req),
    .viol_clr(viol_clr), .access_viol(access_viol), .locked(locked),
    .eng_rd_en(eng_rd_en), .eng_addr(eng_addr), .eng_rdata(eng_rdata),
    .eng_done(eng_done), .eng_abort(eng_abort)
  );

  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = exp_q.pop_front();
      case (it.sig)
        0: act = cpu_rdata;
        1: act = eng_rdata;
        2: act = {7'd0, locked};
        default: act = {7'd0, access_viol};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_val(int sig, logic [7:0] exp, string tag);
    item_t it;
    it.sig = sig; it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic cpu_write(logic [3:0] a, logic [7:0] d);
    cpu_addr = a; cpu_wdata = d; cpu_wr_en = 1'b1;
    step();
    cpu_wr_en = 1'b0;
  endtask

  task automatic cpu_check(logic [3:0] a, logic [7:0] exp, string tag);
    cpu_addr = a;
    expect_val(0, exp, tag);
    step();
  endtask

  task automatic eng_check(logic [3:0] a, logic [7:0] exp, string tag);
    eng_addr = a; eng_rd_en = 1'b1;
    step();
    eng_rd_en = 1'b0;
    expect_val(1, exp, tag);
    step();
  endtask

  task automatic flag_check(int sig, logic v, string tag);
    expect_val(sig, {7'd0, v}, tag);
    step();
  endtask

  task automatic pulse_req();
    cpu_tx_req = 1'b1; step(); cpu_tx_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    flag_check(2, 1'b0, "R1 locked after reset");
    flag_check(3, 1'b0, "R1 viol after reset");
    expect_val(1, 8'h00, "R1 eng_rdata after reset"); step();
    for (int i = 0; i < 10; i++) cpu_check(4'(i), 8'h00, "R1 storage cleared");

    cpu_write(4'd0, 8'hA5);
    cpu_write(4'd1, 8'h3C);
    for (int i = 2; i < 10; i++) cpu_write(4'(i), 8'(8'h10 + i));
    cpu_check(4'd0, 8'hA5, "R2 identifier readback");
    cpu_check(4'd1, 8'h38, "R8 dlc clamped on cpu read");
    for (int i = 2; i < 10; i++) cpu_check(4'(i), 8'(8'h10 + i), "R2 data readback");
    cpu_write(4'd12, 8'hFF);
    cpu_check(4'd12, 8'h00, "R9 high address reads zero");
    eng_check(4'd0, 8'h00, "R7 engine read while released");

    pulse_req();
    flag_check(2, 1'b1, "R3 locked after request");
    cpu_check(4'd0, 8'h00, "R3 cpu read blind while locked");
    cpu_write(4'd0, 8'h00);
    flag_check(3, 1'b1, "R4 violation flag set");
    eng_check(4'd0, 8'hA5, "R7 engine identifier");
    eng_check(4'd1, 8'h3C, "R8 engine sees raw control");
    eng_check(4'd9, 8'h19, "R7 engine last data byte");
    eng_check(4'd11, 8'h00, "R7 engine high address zero");
    pulse_req();
    flag_check(2, 1'b1, "R5 second request keeps lock");
    step(); step();
    flag_check(2, 1'b1, "R6 lock held during retries");
    eng_done = 1'b1; step(); eng_done = 1'b0;
    flag_check(2, 1'b0, "R6 released on done");
    flag_check(2, 1'b0, "R5 ignored request not queued");
    cpu_check(4'd0, 8'hA5, "R3 locked write left byte intact");
    flag_check(3, 1'b1, "R4 violation sticky");
    viol_clr = 1'b1; step(); viol_clr = 1'b0;
    flag_check(3, 1'b0, "R4 violation cleared");

    cpu_write(4'd1, 8'h05);
    cpu_check(4'd1, 8'h05, "R8 small dlc unchanged");
    pulse_req();
    flag_check(2, 1'b1, "R3 relock");
    cpu_wr_en = 1'b1; viol_clr = 1'b1; step();
    cpu_wr_en = 1'b0; viol_clr = 1'b0;
    flag_check(3, 1'b1, "R4 set wins over clear");
    eng_abort = 1'b1; step(); eng_abort = 1'b0;
    flag_check(2, 1'b0, "R6 released on abort");
    cpu_check(4'd1, 8'h05, "R3 control intact after abort");

    step();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule